// File: doc/BRIEF.md
# ECC Memory Error Injector

This block sits in the write path of a small memory subsystem in which every stored 16-bit word carries a 6-bit SEC-DED code. The subsystem holds one data RAM, organised as two banks of 128 words, and three register arrays of 32 entries each. Software can plant a chosen error in one location. It programs a target memory, a bank code and a word address. It also loads one XOR mask for the data bits and another for the check bits, picks a mode, and arms the injector.

No special access is needed to trigger the error. The next ordinary write that lands on the armed location stores the freshly encoded word with both masks XORed in. A later read then runs the word through the decoder. The decoder either returns the data as stored, or returns corrected data with a single-error indication, or flags an uncorrectable double error. Two sticky status flags record that corrections or uncorrectable errors were seen, and software clears them by writing ones.

Top module: `ecc_inject_top`

## Requirements
- R1: After reset, `inj_armed`, `ecc_on`, `stat_sec` and `stat_ded` are all 0.
- R2: A word written without injection reads back unchanged. The read is started by `rd_en` at one clock edge. `rd_valid`, `rd_data`, `rd_err_single` and `rd_err_double` are valid after that edge, with both error outputs 0.
- R3: The data RAM is memory id 0. It takes bank code 0 or 1, which the write port gives as `wr_sel[0]`, and word address 0..0x7F. Only a write to the programmed bank and address is distorted. Writes to the other bank, to other addresses or to another memory are stored clean.
- R4: The register arrays are memory id 1, with target address 0..0x0F. Bank code c in 0..5 selects array c mod 3, which the write port gives as `wr_sel`. Codes 0..2 hit entry 2*ADDR and codes 3..5 hit entry 2*ADDR+1.
- R5: A matching write stores the data XOR the data mask. A one-bit data mask reads back corrected, with `rd_err_single`=1. A two-bit data mask reads back with `rd_err_double`=1.
- R6: A matching write stores the computed check bits XOR the check mask. A one-bit check mask, on any of the 6 check bits, reads back the correct data with `rd_err_single`=1.
- R7: In mode 0 (one-shot), `inj_armed` drops at the edge of the first matching write. Later writes to that location are clean.
- R8: In mode 1 (continuous), every matching write is distorted, and `inj_armed` stays 1 until software writes 0 to the arm register.
- R9: While the ECC enable bit is 0, an armed injector distorts nothing and stays armed.
- R10: While `inj_armed` is 1, writes to the mode, target, data mask and check mask registers are ignored.
- R11: `stat_sec` and `stat_ded` are set one edge after a read that reports the matching error. They stay set through clean reads. Writing 1 to bit 0 (sec) or bit 1 (ded) of the status register clears the flag named by that bit.
- R12: The register selects on `cfg_sel` are: 0 control (bit 0 is the ECC enable), 1 mode (bit 0), 2 target, 3 data mask (16 bits), 4 check mask (6 bits), 5 arm (bit 0), 6 status. The target register holds the memory id in bit 0, the bank code in bits 3:1 and the word address in bits 10:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| wr_en | input | 1 | Memory write strobe |
| wr_mem | input | 1 | Write memory id (0 data RAM, 1 register arrays) |
| wr_sel | input | 2 | RAM bank in bit 0, or register array index |
| wr_addr | input | 8 | RAM word address or array entry |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Memory read strobe |
| rd_mem | input | 1 | Read memory id |
| rd_sel | input | 2 | Read bank or array index |
| rd_addr | input | 8 | Read address or entry |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Decoded (corrected) read data |
| rd_err_single | output | 1 | Read corrected a single-bit error |
| rd_err_double | output | 1 | Read found an uncorrectable error |
| inj_armed | output | 1 | Injector armed |
| ecc_on | output | 1 | ECC enable bit |
| stat_sec | output | 1 | Sticky corrected-error flag |
| stat_ded | output | 1 | Sticky uncorrectable-error flag |

## Verification
The hardest case to bring about is the register-array bank mapping. Six bank codes fold onto three arrays and two word halves. A wrong fold can still distort some write, just the wrong one, so a bench that only looks for an error somewhere would miss it. For each code, the bench arms a one-shot injection. Before the matching write, it writes the opposite half-entry of the same array and the same entry of a neighbouring array, and checks that the injector is still armed after each. It then reads all three locations and checks which one carries the error.

// File: rtl/eccinj_pkg.sv
package eccinj_pkg;
    localparam int DW      = 16;
    localparam int CW      = 6;
    localparam int HW      = 5;
    localparam int NPOS    = DW + HW;
    localparam int RAM_AW  = 7;
    localparam int ENT_AW  = 5;
    localparam int BUS_AW  = 8;
    localparam int NARR    = 3;
    localparam int BANK_W  = 3;

    typedef logic [DW-1:0] data_t;
    typedef logic [CW-1:0] chk_t;

    typedef struct packed {
        chk_t  chk;
        data_t data;
    } word_t;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_MODE  = 3'd1,
        SEL_TGT   = 3'd2,
        SEL_DMASK = 3'd3,
        SEL_CMASK = 3'd4,
        SEL_ARM   = 3'd5,
        SEL_STAT  = 3'd6
    } reg_sel_e;

    typedef enum logic {
        MODE_ONESHOT = 1'b0,
        MODE_CONT    = 1'b1
    } inj_mode_e;

    typedef struct packed {
        logic [RAM_AW-1:0] addr;
        logic [BANK_W-1:0] bank;
        logic              mid;
    } tgt_t;

    typedef struct packed {
        data_t data;
        logic  sec;
        logic  ded;
    } dec_t;

    // lay data and check bits onto Hamming positions 1..NPOS
    function automatic logic [NPOS:0] spread(data_t d, chk_t c);
        logic [NPOS:0] cw;
        int k;
        int j;
        cw = '0;
        k  = 0;
        j  = 0;
        for (int p = 1; p <= NPOS; p++) begin
            if ((p & (p - 1)) == 0) begin
                cw[p] = c[j];
                j++;
            end else begin
                cw[p] = d[k];
                k++;
            end
        end
        return cw;
    endfunction

    function automatic chk_t secded_enc(data_t d);
        logic [NPOS:0] cw;
        chk_t c;
        cw = spread(d, '0);
        c  = '0;
        for (int p = 1; p <= NPOS; p++)
            for (int i = 0; i < HW; i++)
                if (((p >> i) & 1) == 1) c[i] = c[i] ^ cw[p];
        c[CW-1] = ^d ^ ^c[HW-1:0];
        return c;
    endfunction

    function automatic dec_t secded_dec(data_t d, chk_t c);
        logic [NPOS:0] cw;
        logic [HW-1:0] syn;
        logic          ov;
        dec_t          r;
        int            k;
        cw  = spread(d, c);
        syn = '0;
        for (int p = 1; p <= NPOS; p++)
            if (cw[p]) syn = syn ^ HW'(p);
        ov    = ^d ^ ^c;
        r.sec = 1'b0;
        r.ded = 1'b0;
        if (ov) begin
            if (int'(syn) > NPOS) r.ded = 1'b1;
            else begin
                r.sec = 1'b1;
                if (syn != '0) cw[syn] = ~cw[syn];
            end
        end else if (syn != '0) begin
            r.ded = 1'b1;
        end
        k = 0;
        r.data = '0;
        for (int p = 1; p <= NPOS; p++)
            if ((p & (p - 1)) != 0) begin
                r.data[k] = cw[p];
                k++;
            end
        return r;
    endfunction
endpackage

// File: rtl/eccinj_cfg.sv
module eccinj_cfg
    import eccinj_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [2:0] cfg_sel,
    input  data_t      cfg_wdata,
    input  logic       hit,
    input  logic       sec_ev,
    input  logic       ded_ev,
    output logic       ecc_en,
    output inj_mode_e  mode,
    output tgt_t       tgt,
    output data_t      dmask,
    output chk_t       cmask,
    output logic       armed,
    output logic       stat_sec,
    output logic       stat_ded
);
    logic   unlocked;
    logic   clr_sec;
    logic   clr_ded;
    reg_sel_e sel;

    assign sel      = reg_sel_e'(cfg_sel);
    assign unlocked = !armed;
    assign clr_sec  = cfg_we && sel == SEL_STAT && cfg_wdata[0];
    assign clr_ded  = cfg_we && sel == SEL_STAT && cfg_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ecc_en   <= 1'b0;
            mode     <= MODE_ONESHOT;
            tgt      <= '0;
            dmask    <= '0;
            cmask    <= '0;
            armed    <= 1'b0;
            stat_sec <= 1'b0;
            stat_ded <= 1'b0;
        end else begin
            if (cfg_we && sel == SEL_CTRL) ecc_en <= cfg_wdata[0];
            if (cfg_we && unlocked) begin
                case (sel)
                    SEL_MODE:  mode  <= inj_mode_e'(cfg_wdata[0]);
                    SEL_TGT:   tgt   <= tgt_t'(cfg_wdata[$bits(tgt_t)-1:0]);
                    SEL_DMASK: dmask <= cfg_wdata;
                    SEL_CMASK: cmask <= cfg_wdata[CW-1:0];
                    default: ;
                endcase
            end
            if (cfg_we && sel == SEL_ARM) armed <= cfg_wdata[0];
            else if (hit && mode == MODE_ONESHOT) armed <= 1'b0;
            if (sec_ev) stat_sec <= 1'b1;
            else if (clr_sec) stat_sec <= 1'b0;
            if (ded_ev) stat_ded <= 1'b1;
            else if (clr_ded) stat_ded <= 1'b0;
        end
    end
endmodule

// File: rtl/eccinj_match.sv
module eccinj_match
    import eccinj_pkg::*;
(
    input  tgt_t              tgt,
    input  logic              wr_mem,
    input  logic [1:0]        wr_sel,
    input  logic [BUS_AW-1:0] wr_addr,
    output logic              match
);
    logic [1:0]        arr;
    logic              half;
    logic [BUS_AW-1:0] entry;

    always_comb begin
        half  = tgt.bank >= BANK_W'(NARR);
        arr   = half ? 2'(tgt.bank - BANK_W'(NARR)) : 2'(tgt.bank);
        entry = {tgt.addr, half};
        match = 1'b0;
        if (tgt.mid == wr_mem) begin
            if (!wr_mem)
                match = tgt.bank < BANK_W'(2) && wr_sel == {1'b0, tgt.bank[0]}
                        && wr_addr == BUS_AW'(tgt.addr);
            else
                match = tgt.bank < BANK_W'(2 * NARR) && wr_sel == arr
                        && wr_addr == entry;
        end
    end
endmodule

// File: rtl/eccinj_store.sv
module eccinj_store
    import eccinj_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wword,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rword
);
    localparam int DEPTH = 1 << AW;
    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wword;
        if (re) rword <= mem[raddr];
    end
endmodule

// File: rtl/ecc_inject_top.sv
module ecc_inject_top
    import eccinj_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic              wr_en,
    input  logic              wr_mem,
    input  logic [1:0]        wr_sel,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_en,
    input  logic              rd_mem,
    input  logic [1:0]        rd_sel,
    input  logic [BUS_AW-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              rd_err_single,
    output logic              rd_err_double,
    output logic              inj_armed,
    output logic              ecc_on,
    output logic              stat_sec,
    output logic              stat_ded
);
    localparam int NST   = NARR + 1;
    localparam int RAMIW = RAM_AW + 1;

    inj_mode_e cfg_mode;
    tgt_t      cfg_tgt;
    data_t     cfg_dmask;
    chk_t      cfg_cmask;
    logic      wr_match;
    logic      wr_hit;
    word_t     enc_word;
    word_t     st_word;
    dec_t      dec;
    logic      rd_v_q;
    logic [1:0] rd_pick_q;
    logic [NST-1:0] st_we;
    logic [NST-1:0] st_re;
    word_t     st_rword [NST];

    eccinj_cfg u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .hit(wr_hit),
        .sec_ev(rd_v_q && dec.sec), .ded_ev(rd_v_q && dec.ded),
        .ecc_en(ecc_on), .mode(cfg_mode), .tgt(cfg_tgt),
        .dmask(cfg_dmask), .cmask(cfg_cmask), .armed(inj_armed),
        .stat_sec(stat_sec), .stat_ded(stat_ded)
    );

    eccinj_match u_match (
        .tgt(cfg_tgt), .wr_mem(wr_mem), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .match(wr_match)
    );

    assign wr_hit        = wr_en && ecc_on && inj_armed && wr_match;
    assign enc_word.data = wr_data;
    assign enc_word.chk  = secded_enc(wr_data);
    assign st_word.data  = wr_hit ? enc_word.data ^ cfg_dmask : enc_word.data;
    assign st_word.chk   = wr_hit ? enc_word.chk ^ cfg_cmask : enc_word.chk;

    // store 0 is the data RAM, stores 1..NARR are the register arrays
    assign st_we[0] = wr_en && !wr_mem && !wr_sel[1] && !wr_addr[BUS_AW-1];
    assign st_re[0] = rd_en && !rd_mem && !rd_sel[1] && !rd_addr[BUS_AW-1];

    eccinj_store #(.AW(RAMIW)) u_ram (
        .clk(clk), .we(st_we[0]), .waddr({wr_sel[0], wr_addr[RAM_AW-1:0]}),
        .wword(st_word), .re(st_re[0]), .raddr({rd_sel[0], rd_addr[RAM_AW-1:0]}),
        .rword(st_rword[0])
    );

    for (genvar g = 0; g < NARR; g++) begin : g_arr
        assign st_we[g+1] = wr_en && wr_mem && wr_sel == 2'(g)
                            && wr_addr[BUS_AW-1:ENT_AW] == '0;
        assign st_re[g+1] = rd_en && rd_mem && rd_sel == 2'(g)
                            && rd_addr[BUS_AW-1:ENT_AW] == '0;
        eccinj_store #(.AW(ENT_AW)) u_arr (
            .clk(clk), .we(st_we[g+1]), .waddr(wr_addr[ENT_AW-1:0]),
            .wword(st_word), .re(st_re[g+1]), .raddr(rd_addr[ENT_AW-1:0]),
            .rword(st_rword[g+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_v_q    <= 1'b0;
            rd_pick_q <= '0;
        end else begin
            rd_v_q    <= rd_en;
            rd_pick_q <= rd_mem ? 2'(rd_sel + 2'd1) : 2'd0;
        end
    end

    assign dec           = secded_dec(st_rword[rd_pick_q].data, st_rword[rd_pick_q].chk);
    assign rd_valid      = rd_v_q;
    assign rd_data       = dec.data;
    assign rd_err_single = rd_v_q && dec.sec;
    assign rd_err_double = rd_v_q && dec.ded;
endmodule

// File: rtl/eccinj_chk.sv
module eccinj_chk
    import eccinj_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [2:0] cfg_sel,
    input data_t      cfg_wdata,
    input logic       inj_armed,
    input logic       hit,
    input inj_mode_e  mode,
    input tgt_t       tgt,
    input logic       stat_sec,
    input logic       stat_ded,
    input logic       rd_valid,
    input logic       rd_err_single,
    input logic       rd_err_double
);
    // R7
    oneshot_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        inj_armed && hit && mode == MODE_ONESHOT
        && !(cfg_we && cfg_sel == SEL_ARM) |=> !inj_armed);

    // R8
    cont_stays_chk: assert property (@(posedge clk) disable iff (rst)
        inj_armed && hit && mode == MODE_CONT
        && !(cfg_we && cfg_sel == SEL_ARM) |=> inj_armed);

    // R10
    tgt_locked_chk: assert property (@(posedge clk) disable iff (rst)
        inj_armed && cfg_we && cfg_sel == SEL_TGT |=> $stable(tgt));

    // R11
    sec_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        stat_sec && !(cfg_we && cfg_sel == SEL_STAT && cfg_wdata[0]) |=> stat_sec);

    // R11
    ded_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_ded) |-> $past(rd_err_double));

    // R5
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !(rd_err_single && rd_err_double));
endmodule

bind ecc_inject_top eccinj_chk u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .inj_armed(inj_armed), .hit(wr_hit),
    .mode(cfg_mode), .tgt(cfg_tgt), .stat_sec(stat_sec), .stat_ded(stat_ded),
    .rd_valid(rd_valid), .rd_err_single(rd_err_single), .rd_err_double(rd_err_double)
);

// File: tb/ecc_inject_top_bench.sv
module ecc_inject_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        wr_en = 1'b0;
    logic        wr_mem = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_mem = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_addr = '0;
    logic        rd_valid, rd_err_single, rd_err_double;
    logic [15:0] rd_data;
    logic        inj_armed, ecc_on, stat_sec, stat_ded;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    ecc_inject_top u_ecc_inject_top (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] s, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr(input logic m, input logic [1:0] s, input logic [7:0] a,
                      input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_mem = m; wr_sel = s; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // read with the flags settled on return
    task automatic rd(input logic m, input logic [1:0] s, input logic [7:0] a,
                      output logic [15:0] d, output logic se, output logic de);
        @(negedge clk);
        rd_en = 1'b1; rd_mem = m; rd_sel = s; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R2 rd_valid", 32'(rd_valid), 1);
        d = rd_data; se = rd_err_single; de = rd_err_double;
        @(negedge clk);
    endtask

    function automatic logic [15:0] tgt(input logic m, input logic [2:0] b, input logic [6:0] a);
        return {5'd0, a, b, m};
    endfunction

    task automatic setup(input logic md, input logic m, input logic [2:0] b,
                         input logic [6:0] a, input logic [15:0] dm, input logic [5:0] cm);
        cfg(3'd0, 16'h1);
        cfg(3'd1, {15'd0, md});
        cfg(3'd2, tgt(m, b, a));
        cfg(3'd3, dm);
        cfg(3'd4, {10'd0, cm});
        cfg(3'd5, 16'h1);
    endtask

    task automatic t_reset;
        chk("R1 armed", 32'(inj_armed), 0);
        chk("R1 ecc_on", 32'(ecc_on), 0);
        chk("R1 stat_sec", 32'(stat_sec), 0);
        chk("R1 stat_ded", 32'(stat_ded), 0);
    endtask

    task automatic t_clean;
        logic [15:0] d; logic se, de;
        wr(0, 2'd0, 8'h12, 16'hA5C3);
        wr(1, 2'd2, 8'h1F, 16'h0F0F);
        rd(0, 2'd0, 8'h12, d, se, de);
        chk("R2 ram data", 32'(d), 32'hA5C3);
        chk("R2 ram flags", {se, de}, 0);
        rd(1, 2'd2, 8'h1F, d, se, de);
        chk("R2 arr data", 32'(d), 32'h0F0F);
        chk("R2 arr flags", {se, de}, 0);
    endtask

    task automatic t_ram_oneshot;
        logic [15:0] d; logic se, de;
        setup(0, 0, 3'd1, 7'h7F, 16'h0010, 6'h0);
        chk("R12 ecc_on", 32'(ecc_on), 1);
        chk("R12 armed", 32'(inj_armed), 1);
        wr(0, 2'd0, 8'h7F, 16'h1111);
        wr(0, 2'd1, 8'h7E, 16'h2222);
        wr(1, 2'd1, 8'h7F, 16'h3333);
        chk("R3 no match keeps armed", 32'(inj_armed), 1);
        wr(0, 2'd1, 8'h7F, 16'h4444);
        chk("R7 oneshot disarm", 32'(inj_armed), 0);
        rd(0, 2'd1, 8'h7F, d, se, de);
        chk("R5 single data corrected", 32'(d), 32'h4444);
        chk("R5 single flags", {se, de}, 2'b10);
        chk("R11 sec set", 32'(stat_sec), 1);
        rd(0, 2'd0, 8'h7F, d, se, de);
        chk("R3 other bank clean", {d, 1'b0, se, de}, {16'h1111, 3'b0});
        rd(0, 2'd1, 8'h7E, d, se, de);
        chk("R3 other addr clean", {d, 1'b0, se, de}, {16'h2222, 3'b0});
        chk("R11 sec sticky", 32'(stat_sec), 1);
        wr(0, 2'd1, 8'h7F, 16'h5555);
        rd(0, 2'd1, 8'h7F, d, se, de);
        chk("R7 later write clean", {d, 1'b0, se, de}, {16'h5555, 3'b0});
        cfg(3'd6, 16'h2);
        chk("R11 ded clear leaves sec", 32'(stat_sec), 1);
        cfg(3'd6, 16'h1);
        chk("R11 sec cleared", 32'(stat_sec), 0);
    endtask

    task automatic t_cont_lock;
        logic [15:0] d; logic se, de;
        setup(1, 0, 3'd0, 7'h05, 16'h0003, 6'h0);
        cfg(3'd2, tgt(0, 3'd0, 7'h06));
        cfg(3'd3, 16'h0000);
        cfg(3'd1, 16'h0000);
        wr(0, 2'd0, 8'h05, 16'hBEEF);
        chk("R8 still armed", 32'(inj_armed), 1);
        rd(0, 2'd0, 8'h05, d, se, de);
        chk("R5 double flag", {se, de}, 2'b01);
        chk("R11 ded set", 32'(stat_ded), 1);
        wr(0, 2'd0, 8'h05, 16'hCAFE);
        rd(0, 2'd0, 8'h05, d, se, de);
        chk("R8 second write distorted", {se, de}, 2'b01);
        chk("R10 mode locked", 32'(inj_armed), 1);
        wr(0, 2'd0, 8'h06, 16'h0606);
        rd(0, 2'd0, 8'h06, d, se, de);
        chk("R10 target locked", {d, 1'b0, se, de}, {16'h0606, 3'b0});
        cfg(3'd5, 16'h0);
        chk("R8 software disarm", 32'(inj_armed), 0);
        cfg(3'd6, 16'h2);
        chk("R11 ded cleared", 32'(stat_ded), 0);
    endtask

    task automatic t_chk_mask;
        logic [15:0] d; logic se, de;
        setup(0, 0, 3'd0, 7'h20, 16'h0, 6'h04);
        wr(0, 2'd0, 8'h20, 16'h9876);
        rd(0, 2'd0, 8'h20, d, se, de);
        chk("R6 check bit 2", {d, 1'b0, se, de}, {16'h9876, 3'b010});
        setup(0, 0, 3'd0, 7'h21, 16'h0, 6'h20);
        wr(0, 2'd0, 8'h21, 16'h1357);
        rd(0, 2'd0, 8'h21, d, se, de);
        chk("R6 check bit 5", {d, 1'b0, se, de}, {16'h1357, 3'b010});
    endtask

    task automatic t_arrays;
        logic [15:0] d; logic se, de;
        for (int c = 0; c < 6; c++) begin
            logic [1:0] arr, nb;
            logic [7:0] ent, oth;
            arr = 2'(c % 3);
            nb  = 2'((c + 1) % 3);
            ent = (c >= 3) ? 8'd7 : 8'd6;
            oth = (c >= 3) ? 8'd6 : 8'd7;
            setup(0, 1, 3'(c), 7'h03, 16'h8000, 6'h0);
            wr(1, arr, oth, 16'h1111);
            wr(1, nb, ent, 16'h2222);
            chk($sformatf("R4 code %0d no early hit", c), 32'(inj_armed), 1);
            wr(1, arr, ent, 16'h3300 + 16'(c));
            chk($sformatf("R4 code %0d hit", c), 32'(inj_armed), 0);
            rd(1, arr, ent, d, se, de);
            chk($sformatf("R4 code %0d target", c), {d, 1'b0, se, de},
                {16'h3300 + 16'(c), 3'b010});
            rd(1, arr, oth, d, se, de);
            chk($sformatf("R4 code %0d half", c), {d, 1'b0, se, de}, {16'h1111, 3'b0});
            rd(1, nb, ent, d, se, de);
            chk($sformatf("R4 code %0d array", c), {d, 1'b0, se, de}, {16'h2222, 3'b0});
        end
        cfg(3'd6, 16'h3);
    endtask

    task automatic t_ecc_off;
        logic [15:0] d; logic se, de;
        setup(0, 0, 3'd0, 7'h09, 16'h0003, 6'h0);
        cfg(3'd0, 16'h0);
        wr(0, 2'd0, 8'h09, 16'h7777);
        chk("R9 stays armed", 32'(inj_armed), 1);
        rd(0, 2'd0, 8'h09, d, se, de);
        chk("R9 no distortion", {d, 1'b0, se, de}, {16'h7777, 3'b0});
        cfg(3'd5, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_clean();
        t_ram_oneshot();
        t_cont_lock();
        t_chk_mask();
        t_arrays();
        t_ecc_off();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule